// File: doc/BRIEF.md
# Vector Upper-Half State Tracker

This block follows, one retiring instruction per cycle, whether the upper halves of a processor's wide vector register file hold data that differ from zero and from the last saved image. Each retiring instruction arrives as a 3-bit class code with a valid strobe. A three-state machine tracks the upper halves. The states are CLEAN (every upper half is zero), SAVED (the upper halves match the save area) and DIRTY (the upper halves were written and not saved since).

When a legacy narrow vector instruction retires while the tracker is DIRTY, the block raises a penalty request in the same cycle. It then holds a stall output high for `PENALTY_CYCLES` cycles to model the merge of upper-half state. No instruction is accepted while the stall is high. A saturating counter records the number of penalties, and the current state is driven on a 2-bit output.

Class codes: 000 other, 001 wide vector op, 010 legacy narrow vector op, 011 zero-upper op, 100 state save, 101 state restore. Codes 110 and 111 are treated as other.

Top module: `vupper_tracker`

## Requirements
- R1: After reset, `upper_state` is 00 (CLEAN), `stall` is 0 and `penalty_count` is 0.
- R2: An accepted wide vector op (class 001) sets `upper_state` to 10 (DIRTY) on the next cycle, from any state.
- R3: An accepted zero-upper op (class 011) sets `upper_state` to 00 (CLEAN) on the next cycle, from any state.
- R4: An accepted save (100) or restore (101) moves SAVED or DIRTY to 01 (SAVED) on the next cycle, and leaves CLEAN unchanged.
- R5: An accepted narrow op (010), an accepted class 000, 110 or 111, and a cycle with `retire_valid` low all leave `upper_state` unchanged.
- R6: `penalty_req` is high in the same cycle exactly when an accepted narrow op (010) retires while `upper_state` is 10.
- R7: After a penalty, `stall` is high for exactly `PENALTY_CYCLES` consecutive cycles, starting on the next cycle.
- R8: While `stall` is high, an instruction is not accepted. It does not change `upper_state`, it raises no `penalty_req`, and it does not change `penalty_count`.
- R9: A penalty does not change the state: `upper_state` stays 10 through the stall and after it ends.
- R10: `penalty_count` increases by one on the cycle after each penalty. It saturates at its all-ones value (`COUNT_W` bits, default 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | A retiring instruction is presented |
| retire_class | input | 3 | Class code of the retiring instruction |
| stall | output | 1 | Pipeline stall while the penalty is modelled |
| penalty_req | output | 1 | Penalty raised by the instruction in this cycle |
| upper_state | output | 2 | 00 CLEAN, 01 SAVED, 10 DIRTY |
| penalty_count | output | COUNT_W | Saturating count of penalties |

## Verification
The assertions check on every cycle the state moves for wide, zero-upper and save/restore ops, that a penalty starts the stall, that nothing is accepted or changed while the stall is high, and that the counter either steps by one or holds at saturation. Only the bench scenarios can show the exact length of the stall window, that the state is still DIRTY after the stall ends, and that saturation is reached after a long run of penalties. The bench also compares a long random mix of classes, valid gaps and stalls against its own model.

// File: rtl/vut_pkg.sv
package vut_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_SAVED = 2'b01,
        ST_DIRTY = 2'b10
    } upper_state_t;

    typedef enum logic [2:0] {
        CL_OTHER   = 3'b000,
        CL_WIDE    = 3'b001,
        CL_NARROW  = 3'b010,
        CL_ZEROUP  = 3'b011,
        CL_SAVE    = 3'b100,
        CL_RESTORE = 3'b101
    } insn_class_t;

endpackage

// File: rtl/vut_state_fsm.sv
module vut_state_fsm
    import vut_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic [2:0]   cls,
    output upper_state_t state,
    output logic         penalty
);

    upper_state_t state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (accept) begin
            unique case (cls)
                CL_WIDE:   state_nxt = ST_DIRTY;
                CL_ZEROUP: state_nxt = ST_CLEAN;
                CL_SAVE, CL_RESTORE: begin
                    unique case (state)
                        ST_CLEAN: state_nxt = ST_CLEAN;
                        default:  state_nxt = ST_SAVED;
                    endcase
                end
                default:   state_nxt = state;
            endcase
        end
    end

    // outputs
    always_comb begin
        penalty = accept && (cls == CL_NARROW) && (state == ST_DIRTY);
    end

    assert_wide_dirty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls == CL_WIDE) |=> (state == ST_DIRTY));

    assert_zero_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cls == CL_ZEROUP) |=> (state == ST_CLEAN));

    assert_save_from_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cls == CL_SAVE || cls == CL_RESTORE) && state == ST_DIRTY) |=> (state == ST_SAVED));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept) |=> $stable(state));

endmodule

// File: rtl/vut_stall_timer.sv
module vut_stall_timer #(
    parameter int PENALTY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic stall
);

    localparam int CW = $clog2(PENALTY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PENALTY_CYCLES);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (!rst_n)           left <= '0;
        else if (start)       left <= LOAD;
        else if (left != '0)  left <= left - 1'b1;
    end

    always_comb stall = (left != '0);

    assert_start_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> stall);

    assert_no_start_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !start);

endmodule

// File: rtl/vut_sat_count.sv
module vut_sat_count #(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    output logic [COUNT_W-1:0] count
);

    localparam logic [COUNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && count != TOP) |=> (count == $past(count) + 1'b1));

    assert_count_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));

    assert_count_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc) |=> $stable(count));

endmodule

// File: rtl/vupper_tracker.sv
module vupper_tracker
    import vut_pkg::*;
#(
    parameter int PENALTY_CYCLES = 4,
    parameter int COUNT_W        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire_valid,
    input  logic [2:0]         retire_class,
    output logic               stall,
    output logic               penalty_req,
    output logic [1:0]         upper_state,
    output logic [COUNT_W-1:0] penalty_count
);

    logic         accept;
    upper_state_t st;

    always_comb accept = retire_valid && !stall;

    vut_state_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cls     (retire_class),
        .state   (st),
        .penalty (penalty_req)
    );

    vut_stall_timer #(.PENALTY_CYCLES(PENALTY_CYCLES)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .start (penalty_req),
        .stall (stall)
    );

    vut_sat_count #(.COUNT_W(COUNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (penalty_req),
        .count (penalty_count)
    );

    always_comb upper_state = st;

    assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(upper_state));

    assert_no_pen_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !penalty_req);

    assert_pen_keeps_dirty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        penalty_req |=> (upper_state == 2'b10));

endmodule

// File: tb/vupper_tracker_tb_top.sv
module vupper_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PEN = 3;
    localparam int CW  = 4;
    localparam logic [CW-1:0] CMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          retire_valid = 1'b0;
    logic [2:0]    retire_class = 3'b000;
    logic          stall;
    logic          penalty_req;
    logic [1:0]    upper_state;
    logic [CW-1:0] penalty_count;

    int n_checks = 0;
    int n_fail = 0;

    // bench model
    logic [1:0]    m_state = 2'b00;
    int            m_left = 0;
    logic [CW-1:0] m_count = '0;
    string         last_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    vupper_tracker #(.PENALTY_CYCLES(PEN), .COUNT_W(CW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .retire_valid  (retire_valid),
        .retire_class  (retire_class),
        .stall         (stall),
        .penalty_req   (penalty_req),
        .upper_state   (upper_state),
        .penalty_count (penalty_count)
    );

    function automatic logic [1:0] f_next(input logic [1:0] s, input logic [2:0] c);
        case (c)
            3'b001: return 2'b10;
            3'b011: return 2'b00;
            3'b100, 3'b101: return (s == 2'b00) ? 2'b00 : 2'b01;
            default: return s;
        endcase
    endfunction

    function automatic string f_tag(input logic v, input logic [2:0] c, input logic stalled);
        if (stalled) return "R8";
        if (!v) return "R5";
        case (c)
            3'b001: return "R2";
            3'b011: return "R3";
            3'b100, 3'b101: return "R4";
            3'b010: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        check(last_tag, "upper_state", int'(upper_state), int'(m_state));
        check((m_left != 0) ? "R7" : last_tag, "stall", int'(stall), int'(m_left != 0));
        check("R10", "penalty_count", int'(penalty_count), int'(m_count));
    endtask

    // one cycle: outputs checked at negedge, inputs driven, penalty checked, model advanced
    task automatic step(input logic v, input logic [2:0] c);
        logic acc;
        logic pen;
        @(negedge clk);
        check_outputs();
        retire_valid = v;
        retire_class = c;
        #1;
        acc = v && (m_left == 0);
        pen = acc && (c == 3'b010) && (m_state == 2'b10);
        check("R6", "penalty_req", int'(penalty_req), int'(pen));
        last_tag = f_tag(v, c, m_left != 0);
        if (acc) m_state = f_next(m_state, c);
        if (pen) m_left = PEN;
        else if (m_left != 0) m_left--;
        if (pen && m_count != CMAX) m_count++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "reset upper_state", int'(upper_state), 0);
        check("R1", "reset stall", int'(stall), 0);
        check("R1", "reset count", int'(penalty_count), 0);

        // R6 narrow in clean: no penalty; R4 save in clean stays clean
        step(1'b1, 3'b010);
        step(1'b1, 3'b100);
        step(1'b1, 3'b101);
        // R5 unused codes and no valid
        step(1'b1, 3'b110);
        step(1'b1, 3'b111);
        step(1'b0, 3'b001);
        // R2 wide then R6 penalty, R7 stall, R8 ignored inputs during stall
        step(1'b1, 3'b001);
        step(1'b1, 3'b010);
        step(1'b1, 3'b011);
        step(1'b1, 3'b100);
        step(1'b1, 3'b010);
        // R9 still dirty after stall
        step(1'b0, 3'b000);
        step(1'b0, 3'b000);
        // R4 save from dirty, narrow no penalty in saved
        step(1'b1, 3'b100);
        step(1'b1, 3'b010);
        step(1'b1, 3'b101);
        step(1'b1, 3'b001);
        step(1'b1, 3'b101);
        // R3 zero-upper
        step(1'b1, 3'b001);
        step(1'b1, 3'b011);
        step(1'b1, 3'b010);
        // R10 saturation
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 3'b001);
            step(1'b1, 3'b010);
            for (int k = 0; k < PEN; k++) step(1'b0, 3'b000);
        end
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [2:0] c;
            v = ($urandom % 8) != 0;
            c = 3'($urandom % 8);
            if (($urandom % 3) == 0) c = 3'b010;
            step(v, c);
        end
        @(negedge clk);
        check_outputs();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule